// File: doc/BRIEF.md
# Load/Store Scheduler with Read Priority

The block sits between an execution pipeline and one downstream memory port. It is the only path by which the pipeline reaches memory, whether a cached or an external location sits behind the port. Stores are accepted into a small in-order store buffer and written out later. Loads go straight to the port and take it ahead of any buffered store, so writes are the only traffic that is ever deferred.

Before a load uses the port, its word address is compared against every buffered store. If the youngest store to that word writes every byte lane the load asks for, that store's data answers the load and the port sees no read. If the youngest match covers only some lanes, the load waits until the buffer has written that store out, and then reads memory. Load responses return in request order, so a forwarded load waits behind an older load whose memory read is still outstanding. A flush input blocks new requests and is acknowledged once the buffer is empty.

Top module: `lsu_sched`

## Requirements
- R1: After reset, mem_req_valid_o, rsp_valid_o and flush_done_o are 0, and a store request (req_op_i = 1) sees req_ready_o = 1.
- R2: Every accepted store (req_op_i = 1) appears exactly once on the memory port with mem_req_we_o = 1, carrying its address, data and byte enables, in the order the stores were accepted.
- R3: When SB_DEPTH stores are buffered, a store request sees req_ready_o = 0 until an entry drains.
- R4: A load (req_op_i = 0) that needs memory drives the port at once with mem_req_we_o = 0 and its own address, even while stores are buffered and the port is not ready.
- R5: A load whose word address matches a buffered store that writes all of the load's enabled lanes is answered from the buffer and causes no read on the memory port.
- R6: When several buffered stores match a load, the data comes from the most recently accepted one.
- R7: A load whose youngest matching store does not cover all of its lanes is not accepted and drives no read until that store has drained. It then reads memory once.
- R8: Load responses appear on rsp_valid_o in request order, one per load. Byte lane b of rsp_data_o (bits 8b+7..8b) equals the current memory value when load enable bit b is 1, and is zero otherwise.
- R9: While flush_i is 1, req_ready_o is 0. flush_done_o is 1 only while flush_i is 1 and no store is buffered.
- R10: When RSP_DEPTH loads await their response, further loads see req_ready_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request accepted this cycle when valid |
| req_op_i | input | 1 | 0 load, 1 store |
| req_addr_i | input | AW | Word address |
| req_wdata_i | input | DW | Store data |
| req_be_i | input | DW/8 | Byte lane enables |
| rsp_valid_o | output | 1 | Load response valid (no backpressure) |
| rsp_data_o | output | DW | Load data, disabled lanes zero |
| mem_req_valid_o | output | 1 | Memory request valid |
| mem_req_ready_i | input | 1 | Memory accepts request |
| mem_req_we_o | output | 1 | 1 write, 0 read |
| mem_req_addr_o | output | AW | Memory word address |
| mem_req_wdata_o | output | DW | Write data |
| mem_req_be_o | output | DW/8 | Byte enables |
| mem_rsp_valid_i | input | 1 | Read data return, in issue order |
| mem_rsp_data_i | input | DW | Read data |
| flush_i | input | 1 | Drain request, held until acknowledged |
| flush_done_o | output | 1 | Store buffer empty under flush |

## Verification
The bench builds the block with AW = 8, SB_DEPTH = 4 and RSP_DEPTH = 2, behind a memory model with a three-cycle read return. The shallow response queue lets two back-to-back memory loads fill it, so the load stall can be seen. The four-entry buffer fills in a few stores while the port is held not ready. Holding the port off also keeps stores buffered, so the bench can set up load priority, youngest-match forwarding and partial-match stalls. The three-cycle read latency makes a forwarded load wait behind an older memory read.

// File: rtl/lsu_pkg.sv
`timescale 1ns/1ps
package lsu_pkg;
  typedef enum logic {OP_LOAD = 1'b0, OP_STORE = 1'b1} lsu_op_e;
  localparam int LANE_W = 8;
endpackage

// File: rtl/lsu_store_buf.sv
`timescale 1ns/1ps
module lsu_store_buf #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  localparam int BW   = DW / lsu_pkg::LANE_W,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [AW-1:0] push_addr_i,
  input  logic [DW-1:0] push_data_i,
  input  logic [BW-1:0] push_be_i,
  input  logic          pop_i,
  input  logic [AW-1:0] look_addr_i,
  input  logic [BW-1:0] look_be_i,
  output logic          full_o,
  output logic [CW-1:0] count_o,
  output logic [AW-1:0] head_addr_o,
  output logic [DW-1:0] head_data_o,
  output logic [BW-1:0] head_be_o,
  output logic          hit_full_o,
  output logic          hit_part_o,
  output logic [DW-1:0] hit_data_o
);
  logic [AW-1:0] addr_q [DEPTH];
  logic [DW-1:0] data_q [DEPTH];
  logic [BW-1:0] be_q   [DEPTH];
  logic [IW-1:0] head_q, tail_q, sel;
  logic [CW-1:0] cnt_q;
  logic          hit;

  function automatic logic [IW-1:0] nxt(input logic [IW-1:0] p);
    return (p == IW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i) begin
      addr_q[tail_q] <= push_addr_i;
      data_q[tail_q] <= push_data_i;
      be_q[tail_q]   <= push_be_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_i) tail_q <= nxt(tail_q);
      if (pop_i)  head_q <= nxt(head_q);
      cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
    end
  end

  // scan oldest to youngest; last match wins
  always_comb begin
    hit = 1'b0;
    sel = head_q;
    for (int k = 0; k < DEPTH; k++) begin
      int idx;
      idx = (int'(head_q) + k) % DEPTH;
      if (k < int'(cnt_q) && addr_q[idx] == look_addr_i) begin
        hit = 1'b1;
        sel = IW'(idx);
      end
    end
  end

  assign hit_full_o  = hit && ((look_be_i & ~be_q[sel]) == '0);
  assign hit_part_o  = hit && !hit_full_o;
  assign hit_data_o  = data_q[sel];
  assign full_o      = (cnt_q == CW'(DEPTH));
  assign count_o     = cnt_q;
  assign head_addr_o = addr_q[head_q];
  assign head_data_o = data_q[head_q];
  assign head_be_o   = be_q[head_q];
endmodule

// File: rtl/lsu_rsp_order.sv
`timescale 1ns/1ps
module lsu_rsp_order #(
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  localparam int BW   = DW / lsu_pkg::LANE_W,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          push_fwd_i,
  input  logic [DW-1:0] push_data_i,
  input  logic [BW-1:0] push_be_i,
  input  logic          mem_valid_i,
  input  logic [DW-1:0] mem_data_i,
  output logic          full_o,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_data_o
);
  typedef struct packed {
    logic          fwd;
    logic [BW-1:0] be;
    logic [DW-1:0] data;
  } ent_t;

  ent_t          ent_q [DEPTH];
  logic [DW-1:0] rd_q  [DEPTH];
  logic [IW-1:0] eh_q, et_q, rh_q, rt_q;
  logic [CW-1:0] ec_q, rc_q;
  ent_t          head;
  logic          rd_pop;
  logic [DW-1:0] raw, lane_mask;

  function automatic logic [IW-1:0] nxt(input logic [IW-1:0] p);
    return (p == IW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign head        = ent_q[eh_q];
  assign rsp_valid_o = (ec_q != '0) && (head.fwd || rc_q != '0);
  assign rd_pop      = rsp_valid_o && !head.fwd;
  assign full_o      = (ec_q == CW'(DEPTH));

  always_ff @(posedge clk_i) begin
    if (push_i)      ent_q[et_q] <= '{fwd: push_fwd_i, be: push_be_i, data: push_data_i};
    if (mem_valid_i) rd_q[rt_q]  <= mem_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eh_q <= '0; et_q <= '0; ec_q <= '0;
      rh_q <= '0; rt_q <= '0; rc_q <= '0;
    end else begin
      if (push_i)      et_q <= nxt(et_q);
      if (rsp_valid_o) eh_q <= nxt(eh_q);
      ec_q <= ec_q + CW'(push_i) - CW'(rsp_valid_o);
      if (mem_valid_i) rt_q <= nxt(rt_q);
      if (rd_pop)      rh_q <= nxt(rh_q);
      rc_q <= rc_q + CW'(mem_valid_i) - CW'(rd_pop);
    end
  end

  always_comb begin
    for (int b = 0; b < BW; b++) lane_mask[b*lsu_pkg::LANE_W +: lsu_pkg::LANE_W] = {lsu_pkg::LANE_W{head.be[b]}};
  end

  assign raw        = head.fwd ? head.data : rd_q[rh_q];
  assign rsp_data_o = raw & lane_mask;
endmodule

// File: rtl/lsu_port_arb.sv
`timescale 1ns/1ps
module lsu_port_arb #(
  parameter int AW  = 32,
  parameter int DW  = 32,
  localparam int BW = DW / lsu_pkg::LANE_W
) (
  input  logic          ld_req_i,
  input  logic [AW-1:0] ld_addr_i,
  input  logic [BW-1:0] ld_be_i,
  input  logic          st_valid_i,
  input  logic [AW-1:0] st_addr_i,
  input  logic [DW-1:0] st_data_i,
  input  logic [BW-1:0] st_be_i,
  input  logic          mem_ready_i,
  output logic          mem_valid_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic [BW-1:0] mem_be_o,
  output logic          st_pop_o
);
  // reads win the port outright
  assign mem_valid_o = ld_req_i || st_valid_i;
  assign mem_we_o    = !ld_req_i;
  assign mem_addr_o  = ld_req_i ? ld_addr_i : st_addr_i;
  assign mem_wdata_o = ld_req_i ? '0 : st_data_i;
  assign mem_be_o    = ld_req_i ? ld_be_i : st_be_i;
  assign st_pop_o    = st_valid_i && !ld_req_i && mem_ready_i;
endmodule

// File: rtl/lsu_sched.sv
`timescale 1ns/1ps
module lsu_sched
  import lsu_pkg::*;
#(
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int SB_DEPTH  = 4,
  parameter int RSP_DEPTH = 4,
  localparam int BW       = DW / LANE_W,
  localparam int SCW      = $clog2(SB_DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_op_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  input  logic [BW-1:0] req_be_i,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_data_o,
  output logic          mem_req_valid_o,
  input  logic          mem_req_ready_i,
  output logic          mem_req_we_o,
  output logic [AW-1:0] mem_req_addr_o,
  output logic [DW-1:0] mem_req_wdata_o,
  output logic [BW-1:0] mem_req_be_o,
  input  logic          mem_rsp_valid_i,
  input  logic [DW-1:0] mem_rsp_data_i,
  input  logic          flush_i,
  output logic          flush_done_o
);
  logic           is_st, ld_req, st_req, ld_go, ld_issue, ld_acc, st_acc;
  logic           sb_full, fwd_hit, part_hit, st_pop, rq_full;
  logic [SCW-1:0] sb_count;
  logic [AW-1:0]  hd_addr;
  logic [DW-1:0]  hd_data, fwd_data;
  logic [BW-1:0]  hd_be;

  assign is_st    = (req_op_i == OP_STORE);
  assign ld_req   = req_valid_i && !is_st;
  assign st_req   = req_valid_i && is_st;
  assign ld_go    = ld_req && !flush_i && !rq_full && !part_hit;
  assign ld_issue = ld_go && !fwd_hit;
  assign ld_acc   = ld_go && (fwd_hit || mem_req_ready_i);
  assign st_acc   = st_req && !flush_i && !sb_full;

  assign req_ready_o  = !flush_i && (is_st ? !sb_full
                                           : (!rq_full && !part_hit && (fwd_hit || mem_req_ready_i)));
  assign flush_done_o = flush_i && (sb_count == '0);

  lsu_store_buf #(.AW(AW), .DW(DW), .DEPTH(SB_DEPTH)) u_sb (
    .clk_i, .rst_ni,
    .push_i(st_acc), .push_addr_i(req_addr_i), .push_data_i(req_wdata_i), .push_be_i(req_be_i),
    .pop_i(st_pop),
    .look_addr_i(req_addr_i), .look_be_i(req_be_i),
    .full_o(sb_full), .count_o(sb_count),
    .head_addr_o(hd_addr), .head_data_o(hd_data), .head_be_o(hd_be),
    .hit_full_o(fwd_hit), .hit_part_o(part_hit), .hit_data_o(fwd_data)
  );

  lsu_port_arb #(.AW(AW), .DW(DW)) u_arb (
    .ld_req_i(ld_issue), .ld_addr_i(req_addr_i), .ld_be_i(req_be_i),
    .st_valid_i(sb_count != '0), .st_addr_i(hd_addr), .st_data_i(hd_data), .st_be_i(hd_be),
    .mem_ready_i(mem_req_ready_i),
    .mem_valid_o(mem_req_valid_o), .mem_we_o(mem_req_we_o), .mem_addr_o(mem_req_addr_o),
    .mem_wdata_o(mem_req_wdata_o), .mem_be_o(mem_req_be_o), .st_pop_o(st_pop)
  );

  lsu_rsp_order #(.DW(DW), .DEPTH(RSP_DEPTH)) u_rsp (
    .clk_i, .rst_ni,
    .push_i(ld_acc), .push_fwd_i(fwd_hit), .push_data_i(fwd_data), .push_be_i(req_be_i),
    .mem_valid_i(mem_rsp_valid_i), .mem_data_i(mem_rsp_data_i),
    .full_o(rq_full), .rsp_valid_o(rsp_valid_o), .rsp_data_o(rsp_data_o)
  );
endmodule

// File: rtl/lsu_sched_chk.sv
`timescale 1ns/1ps
module lsu_sched_chk #(
  parameter int AW       = 32,
  parameter int SB_DEPTH = 4,
  localparam int SCW     = $clog2(SB_DEPTH + 1)
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           req_valid_i,
  input logic           req_ready_o,
  input logic           req_op_i,
  input logic [AW-1:0]  req_addr_i,
  input logic           rsp_valid_o,
  input logic           mem_req_valid_o,
  input logic           mem_req_we_o,
  input logic [AW-1:0]  mem_req_addr_o,
  input logic           flush_i,
  input logic           flush_done_o,
  input logic           fwd_hit,
  input logic [SCW-1:0] sb_count
);
  logic        ld_acc;
  logic [15:0] pend_q;

  assign ld_acc = req_valid_i && req_ready_o && !req_op_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= pend_q + 16'(ld_acc) - 16'(rsp_valid_o);
  end

  // R4
  ld_issue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_acc && !fwd_hit) |-> (mem_req_valid_o && !mem_req_we_o && mem_req_addr_o == req_addr_i));
  // R5
  fwd_no_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_acc && fwd_hit) |-> !(mem_req_valid_o && !mem_req_we_o));
  // R3
  sb_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sb_count == SCW'(SB_DEPTH) && req_valid_i && req_op_i) |-> !req_ready_o);
  // R9
  flush_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |-> !req_ready_o);
  // R9
  flush_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_done_o |-> (flush_i && sb_count == '0));
  // R8
  rsp_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (pend_q != '0));
endmodule

bind lsu_sched lsu_sched_chk #(.AW(AW), .SB_DEPTH(SB_DEPTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
  .req_op_i(req_op_i), .req_addr_i(req_addr_i), .rsp_valid_o(rsp_valid_o),
  .mem_req_valid_o(mem_req_valid_o), .mem_req_we_o(mem_req_we_o), .mem_req_addr_o(mem_req_addr_o),
  .flush_i(flush_i), .flush_done_o(flush_done_o), .fwd_hit(fwd_hit), .sb_count(sb_count)
);

// File: tb/sim_lsu_sched.sv
`timescale 1ns/1ps
module sim_lsu_sched;
  localparam int AW = 8, DW = 32, BW = 4, SBD = 4, RQD = 2, LAT = 3;

  logic          clk = 1'b0, rst_ni = 1'b0;
  logic          req_valid_i = 1'b0, req_op_i = 1'b1;
  logic [AW-1:0] req_addr_i = '0;
  logic [DW-1:0] req_wdata_i = '0;
  logic [BW-1:0] req_be_i = '0;
  logic          req_ready_o, rsp_valid_o;
  logic [DW-1:0] rsp_data_o;
  logic          mem_req_valid_o, mem_req_ready_i, mem_req_we_o;
  logic [AW-1:0] mem_req_addr_o;
  logic [DW-1:0] mem_req_wdata_o;
  logic [BW-1:0] mem_req_be_o;
  logic          mem_rsp_valid_i = 1'b0;
  logic [DW-1:0] mem_rsp_data_i = '0;
  logic          flush_i = 1'b0, flush_done_o;
  bit            mem_rdy = 1'b0, done = 1'b0;

  assign mem_req_ready_i = mem_rdy;

  lsu_sched #(.AW(AW), .DW(DW), .SB_DEPTH(SBD), .RSP_DEPTH(RQD)) u0 (
    .clk_i(clk), .rst_ni, .req_valid_i, .req_ready_o, .req_op_i, .req_addr_i, .req_wdata_i,
    .req_be_i, .rsp_valid_o, .rsp_data_o, .mem_req_valid_o, .mem_req_ready_i, .mem_req_we_o,
    .mem_req_addr_o, .mem_req_wdata_o, .mem_req_be_o, .mem_rsp_valid_i, .mem_rsp_data_i,
    .flush_i, .flush_done_o
  );

  always #2 clk = ~clk;

  logic [DW-1:0] ref_mem [64];
  logic [DW-1:0] mem     [64];
  logic [DW-1:0] exp_rsp [$];
  string         exp_tag [$];
  logic [AW+DW+BW-1:0] exp_st [$];
  bit            pv [LAT];
  logic [DW-1:0] pd [LAT];
  int checks = 0, errors = 0, rd_cnt = 0;

  function automatic logic [DW-1:0] lanes(input logic [BW-1:0] be);
    for (int b = 0; b < BW; b++) lanes[b*8 +: 8] = {8{be[b]}};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // mode: 1 port shows this read, 2 first look not ready, 3 port shows store and not ready
  task automatic send(input bit st, input int a, input logic [DW-1:0] d, input logic [BW-1:0] be,
                      input int mode, input string tag);
    @(negedge clk);
    req_valid_i = 1'b1; req_op_i = st; req_addr_i = AW'(a); req_wdata_i = d; req_be_i = be;
    #1;
    if (mode == 1) check(mem_req_valid_o && !mem_req_we_o && mem_req_addr_o == AW'(a), tag,
                         {mem_req_valid_o, mem_req_we_o, mem_req_addr_o}, {1'b1, 1'b0, AW'(a)});
    if (mode == 2) check(!req_ready_o, tag, req_ready_o, 0);
    if (mode == 3) check(mem_req_valid_o && mem_req_we_o && !req_ready_o, tag,
                         {mem_req_valid_o, mem_req_we_o, req_ready_o}, 3'b110);
    while (!req_ready_o) begin @(negedge clk); #1; end
    if (st) begin
      ref_mem[a] = (ref_mem[a] & ~lanes(be)) | (d & lanes(be));
      exp_st.push_back({AW'(a), d, be});
    end else begin
      exp_rsp.push_back(ref_mem[a] & lanes(be));
      exp_tag.push_back(tag);
    end
    @(posedge clk); #0.5;
    req_valid_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // memory model and response monitor
  always @(negedge clk) begin
    #1.5;
    if (rst_ni) begin
      for (int i = LAT - 1; i > 0; i--) begin pv[i] = pv[i-1]; pd[i] = pd[i-1]; end
      pv[0] = 1'b0;
      if (mem_req_valid_o && mem_req_ready_i) begin
        int a;
        a = int'(mem_req_addr_o[5:0]);
        if (mem_req_we_o) begin
          if (exp_st.size() == 0) check(0, "R2", {mem_req_addr_o, mem_req_wdata_o}, 0);
          else begin
            logic [AW+DW+BW-1:0] e;
            e = exp_st.pop_front();
            check({mem_req_addr_o, mem_req_wdata_o, mem_req_be_o} == e, "R2",
                  {mem_req_addr_o, mem_req_wdata_o, mem_req_be_o}, e);
          end
          mem[a] = (mem[a] & ~lanes(mem_req_be_o)) | (mem_req_wdata_o & lanes(mem_req_be_o));
        end else begin
          pv[0] = 1'b1; pd[0] = mem[a]; rd_cnt++;
        end
      end
      mem_rsp_valid_i = pv[LAT-1];
      mem_rsp_data_i  = pd[LAT-1];
      if (rsp_valid_o) begin
        if (exp_rsp.size() == 0) check(0, "R8", rsp_data_o, 0);
        else begin
          logic [DW-1:0] e;
          string t;
          e = exp_rsp.pop_front();
          t = exp_tag.pop_front();
          check(rsp_data_o == e, t, rsp_data_o, e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int rd0;
    for (int i = 0; i < 64; i++) begin
      ref_mem[i] = 32'hA500_0000 ^ (i * 32'h0101_0101);
      mem[i] = ref_mem[i];
    end
    for (int i = 0; i < LAT; i++) begin pv[i] = 1'b0; pd[i] = '0; end
    idle(3);
    rst_ni = 1'b1;
    @(negedge clk); #1;
    // R1
    check(req_ready_o && !mem_req_valid_o && !rsp_valid_o && !flush_done_o, "R1",
          {req_ready_o, mem_req_valid_o, rsp_valid_o, flush_done_o}, 4'b1000);

    // R5: store then fully covered load, no read
    mem_rdy = 1'b1;
    rd0 = rd_cnt;
    send(1, 3, 32'h1122_3344, 4'hF, 0, "R2");
    send(0, 3, '0, 4'hF, 0, "R5");
    idle(8);
    check(rd_cnt == rd0, "R5", rd_cnt, rd0);

    // R6: two stores to one word, youngest forwards
    mem_rdy = 1'b0;
    send(1, 5, 32'hDEAD_0001, 4'hF, 0, "R2");
    send(1, 5, 32'hCAFE_0002, 4'hF, 0, "R2");
    send(0, 5, '0, 4'h6, 0, "R6");

    // R4: unrelated load takes the port while stores wait
    fork
      send(0, 9, '0, 4'hF, 1, "R4");
      begin idle(3); mem_rdy = 1'b1; end
    join
    idle(10);

    // R7: partial cover stalls until drain, then reads once
    mem_rdy = 1'b0;
    send(1, 7, 32'h0000_BEEF, 4'h3, 0, "R2");
    rd0 = rd_cnt;
    fork
      send(0, 7, '0, 4'hF, 3, "R7");
      begin idle(3); mem_rdy = 1'b1; end
    join
    idle(8);
    check(rd_cnt == rd0 + 1, "R7", rd_cnt, rd0 + 1);

    // R8: forwarded load waits behind an older memory read
    mem_rdy = 1'b0;
    send(1, 13, 32'h5A5A_1313, 4'hF, 0, "R2");
    fork
      send(0, 12, '0, 4'h9, 0, "R8");
      begin idle(1); mem_rdy = 1'b1; end
    join
    rd0 = rd_cnt;
    send(0, 13, '0, 4'hF, 0, "R8");
    idle(10);
    check(rd_cnt == rd0, "R5", rd_cnt, rd0);

    // R10: response queue full
    send(0, 30, '0, 4'hF, 0, "R10");
    send(0, 31, '0, 4'hC, 0, "R10");
    send(0, 32, '0, 4'hF, 2, "R10");
    idle(10);

    // R3: buffer full
    mem_rdy = 1'b0;
    for (int i = 0; i < SBD; i++) send(1, 40 + i, 32'h4000_0000 + i, 4'hF, 0, "R2");
    fork
      send(1, 44, 32'h4444_4444, 4'hA, 2, "R3");
      begin idle(3); mem_rdy = 1'b1; end
    join
    send(0, 44, '0, 4'hF, 0, "R8");
    idle(10);

    // R9: flush waits for drain
    mem_rdy = 1'b0;
    send(1, 50, 32'h5050_5050, 4'hF, 0, "R2");
    send(1, 51, 32'h5151_5151, 4'h5, 0, "R2");
    @(negedge clk);
    flush_i = 1'b1;
    #1;
    check(!flush_done_o, "R9", flush_done_o, 0);
    check(!req_ready_o, "R9", req_ready_o, 0);
    idle(1);
    mem_rdy = 1'b1;
    for (int i = 0; i < 20 && !flush_done_o; i++) begin @(negedge clk); #1; end
    check(flush_done_o && exp_st.size() == 0, "R9", {flush_done_o, 8'(exp_st.size())}, 9'h100);
    check(!req_ready_o, "R9", req_ready_o, 0);
    @(negedge clk);
    flush_i = 1'b0;
    #1;
    check(!flush_done_o, "R9", flush_done_o, 0);
    send(0, 51, '0, 4'hF, 0, "R8");

    idle(20);
    check(exp_rsp.size() == 0, "R8", exp_rsp.size(), 0);
    check(exp_st.size() == 0, "R2", exp_st.size(), 0);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule